// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a register-mapped timer that runs on the bus clock and counts pulses of a slow-clock tick enable. A prescaler divides the tick pulses and steps a free-running real-time counter. An alarm register is compared against that counter and raises an event when the counter steps onto the stored value. A second, independent interval timer counts raw tick pulses and raises an event each time a programmed period elapses, then reloads itself.

Four event flags are gathered in a status register: interval elapsed, watchdog overflow (raised by an external pulse), counter increment and alarm match. Reading the status register returns the flags and clears them. A mask register, changed through separate write-one-to-set and write-one-to-clear addresses, selects which flags drive the single level-sensitive interrupt line.

Software reaches every register through one read/write port with a 3-bit word address. Read data is combinational and belongs to the address presented in the same cycle. The clear caused by a status read takes effect at the clock edge that ends that cycle. The data width equals the counter width, which must be at least the tick-counter width.

Top module: `slow_tick_timer`

## Requirements
- R1: The real-time counter is CNT_W bits wide (default 20), reads at address 3, and after its all-ones value the next increment gives 0.
- R2: The counter advances once every P tick pulses, where P is the prescaler value at address 0 (low TICK_W bits). P=1 counts every tick and P=0 means 2^TICK_W. Writing the prescaler restarts its tick count. With no tick pulse the counter holds.
- R3: After reset the prescaler reads 32768, and the counter, alarm, period, status and mask all read 0, with the interrupt low.
- R4: The alarm flag (status bit 3) is set when the counter steps to a value equal to the alarm register at address 1. Writing the alarm with the current count does not fire until the counter has wrapped all the way round.
- R5: The interval flag (status bit 0) is set once every N tick pulses, where N is the period at address 2, independent of the prescaler. Writing the period restarts the interval count, and a period of 0 produces no interval events.
- R6: The increment flag (status bit 2) is set on every counter increment whatever the mask holds. The watchdog flag (status bit 1) is set by a one-cycle pulse on wdog_ovf_i.
- R7: A read of address 4 returns the status flags and clears them at the end of that cycle. An event arriving in the same cycle as the read stays set afterwards.
- R8: A write to address 5 sets the mask bits written as 1. A write to address 6 clears the mask bits written as 1. Zero bits leave the mask unchanged. The mask reads at address 7, using the same bit positions as the status register.
- R9: irq_o is high exactly when some status flag and its mask bit are both set. It stays high until a status read clears the flag or the mask bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow-clock tick enable, one bus cycle per tick |
| wdog_ovf_i | input | 1 | Watchdog overflow event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, same cycle |
| irq_o | output | 1 | Level interrupt request |

## Verification
A prescaler divide count that is off by one shows up at the counter read port after as few as one prescaler period, and it grows with every later period. A wrong wrap or a wrong alarm compare only becomes visible once the counter has gone all the way round, so the bench drives a full 2^CNT_W tick wrap with the prescaler at 1. A lost event during a status read shows up on the very next status read as a missing bit. A corrupted mask bit shows up on irq_o in the cycle after the matching flag sets.

// File: rtl/st_pkg.sv
package st_pkg;
    localparam int FLAG_N   = 4;
    localparam int FLG_PIT  = 0;
    localparam int FLG_WDOG = 1;
    localparam int FLG_INC  = 2;
    localparam int FLG_ALM  = 3;

    typedef enum logic [2:0] {
        ADR_PRESC  = 3'd0,
        ADR_ALARM  = 3'd1,
        ADR_PERIOD = 3'd2,
        ADR_COUNT  = 3'd3,
        ADR_STATUS = 3'd4,
        ADR_IEN    = 3'd5,
        ADR_IDIS   = 3'd6,
        ADR_MASK   = 3'd7
    } st_addr_e;
endpackage

// File: rtl/st_rtc.sv
module st_rtc #(
    parameter int CNT_W     = 20,
    parameter int TICK_W    = 16,
    parameter int PRESC_RST = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              presc_we_i,
    input  logic              alarm_we_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [TICK_W-1:0] presc_o,
    output logic [CNT_W-1:0]  alarm_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              inc_o,
    output logic              alm_o
);
    localparam logic [TICK_W-1:0] PRESC_INIT = TICK_W'(PRESC_RST);
    localparam logic [TICK_W-1:0] TICK_ONE   = TICK_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE    = CNT_W'(1);

    typedef struct packed {
        logic [TICK_W-1:0] presc;
        logic [TICK_W-1:0] div;
        logic [CNT_W-1:0]  alarm;
        logic [CNT_W-1:0]  cnt;
    } rtc_t;

    rtc_t s_d, s_q;
    logic [TICK_W-1:0] div_last;
    logic [CNT_W-1:0]  cnt_next;

    always_comb begin
        s_d      = s_q;
        inc_o    = 1'b0;
        alm_o    = 1'b0;
        div_last = s_q.presc - TICK_ONE;   // 0 wraps to all ones: 2^TICK_W ticks
        cnt_next = s_q.cnt + CNT_ONE;
        if (presc_we_i) begin
            s_d.presc = wdata_i[TICK_W-1:0];
            s_d.div   = '0;
        end else if (tick_i) begin
            if (s_q.div == div_last) begin
                s_d.div = '0;
                s_d.cnt = cnt_next;
                inc_o   = 1'b1;
                alm_o   = (cnt_next == s_q.alarm);
            end else begin
                s_d.div = s_q.div + TICK_ONE;
            end
        end
        if (alarm_we_i) begin
            s_d.alarm = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{presc: PRESC_INIT, div: '0, alarm: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign presc_o = s_q.presc;
    assign alarm_o = s_q.alarm;
    assign cnt_o   = s_q.cnt;

    // R1: an increment moves the counter by exactly one, modulo 2^CNT_W
    a_r1_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        inc_o |=> (s_q.cnt == $past(s_q.cnt) + CNT_ONE));

    // R2: without a tick pulse the counter holds
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (s_q.cnt == $past(s_q.cnt)));

    // R4: an alarm event leaves the counter on the alarm value
    a_r4_match_value: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_o && !alarm_we_i) |=> (s_q.cnt == s_q.alarm));
endmodule

// File: rtl/st_pit.sv
module st_pit #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              period_we_i,
    input  logic [TICK_W-1:0] wdata_i,
    output logic [TICK_W-1:0] period_o,
    output logic              pit_o
);
    localparam logic [TICK_W-1:0] TICK_ONE = TICK_W'(1);

    typedef struct packed {
        logic [TICK_W-1:0] period;
        logic [TICK_W-1:0] cnt;
    } pit_t;

    pit_t s_d, s_q;
    logic [TICK_W-1:0] cnt_last;

    always_comb begin
        s_d      = s_q;
        pit_o    = 1'b0;
        cnt_last = s_q.period - TICK_ONE;
        if (period_we_i) begin
            s_d.period = wdata_i;
            s_d.cnt    = '0;
        end else if (tick_i && (s_q.period != '0)) begin
            if (s_q.cnt == cnt_last) begin
                s_d.cnt = '0;
                pit_o   = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + TICK_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{period: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign period_o = s_q.period;

    // R5: a zero period never yields an interval event
    a_r5_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.period == '0) |-> !pit_o);

    // R5: writing the period restarts the interval count
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        period_we_i |=> (s_q.cnt == '0));

    // R5: the count never reaches the period
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.period != '0) |-> (s_q.cnt < s_q.period));
endmodule

// File: rtl/st_evt.sv
module st_evt #(
    parameter int FLAG_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] evt_i,
    input  logic              clr_i,
    input  logic              ien_we_i,
    input  logic              idis_we_i,
    input  logic [FLAG_N-1:0] bits_i,
    output logic [FLAG_N-1:0] flags_o,
    output logic [FLAG_N-1:0] mask_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [FLAG_N-1:0] flags;
        logic [FLAG_N-1:0] mask;
    } evt_t;

    evt_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.flags = (clr_i ? '0 : s_q.flags) | evt_i;
        if (ien_we_i) begin
            s_d.mask = s_d.mask | bits_i;
        end
        if (idis_we_i) begin
            s_d.mask = s_d.mask & ~bits_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{flags: '0, mask: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign flags_o = s_q.flags;
    assign mask_o  = s_q.mask;
    assign irq_o   = |(s_q.flags & s_q.mask);

    // R7: an event coinciding with a status read survives the clear
    a_r7_keep_event: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (evt_i != '0)) |=> ((s_q.flags & $past(evt_i)) == $past(evt_i)));

    // R7: a read with no new event leaves the status empty
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (evt_i == '0)) |=> (s_q.flags == '0));

    // R8: enable writes set the chosen mask bits
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_we_i && !idis_we_i) |=> ((s_q.mask & $past(bits_i)) == $past(bits_i)));

    // R8: disable writes clear the chosen mask bits
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        idis_we_i |=> ((s_q.mask & $past(bits_i)) == '0));
endmodule

// File: rtl/slow_tick_timer.sv
module slow_tick_timer #(
    parameter int CNT_W     = 20,
    parameter int TICK_W    = 16,
    parameter int PRESC_RST = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wdog_ovf_i,
    input  logic             reg_we,
    input  logic             reg_re,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq_o
);
    import st_pkg::*;

    st_addr_e adr;
    logic presc_we, alarm_we, period_we, ien_we, idis_we, stat_rd;
    logic [TICK_W-1:0] presc, period;
    logic [CNT_W-1:0]  alarm, cnt;
    logic inc_evt, alm_evt, pit_evt;
    logic [FLAG_N-1:0] evt, flags, mask;

    assign adr = st_addr_e'(reg_addr);

    always_comb begin
        presc_we  = reg_we && (adr == ADR_PRESC);
        alarm_we  = reg_we && (adr == ADR_ALARM);
        period_we = reg_we && (adr == ADR_PERIOD);
        ien_we    = reg_we && (adr == ADR_IEN);
        idis_we   = reg_we && (adr == ADR_IDIS);
        stat_rd   = reg_re && (adr == ADR_STATUS);
    end

    st_rtc #(.CNT_W(CNT_W), .TICK_W(TICK_W), .PRESC_RST(PRESC_RST)) rtc_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .presc_we_i(presc_we), .alarm_we_i(alarm_we), .wdata_i(reg_wdata),
        .presc_o(presc), .alarm_o(alarm), .cnt_o(cnt),
        .inc_o(inc_evt), .alm_o(alm_evt)
    );

    st_pit #(.TICK_W(TICK_W)) pit_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .period_we_i(period_we), .wdata_i(reg_wdata[TICK_W-1:0]),
        .period_o(period), .pit_o(pit_evt)
    );

    always_comb begin
        evt           = '0;
        evt[FLG_PIT]  = pit_evt;
        evt[FLG_WDOG] = wdog_ovf_i;
        evt[FLG_INC]  = inc_evt;
        evt[FLG_ALM]  = alm_evt;
    end

    st_evt #(.FLAG_N(FLAG_N)) evt_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(stat_rd),
        .ien_we_i(ien_we), .idis_we_i(idis_we), .bits_i(reg_wdata[FLAG_N-1:0]),
        .flags_o(flags), .mask_o(mask), .irq_o(irq_o)
    );

    always_comb begin
        case (adr)
            ADR_PRESC:  reg_rdata = CNT_W'(presc);
            ADR_ALARM:  reg_rdata = alarm;
            ADR_PERIOD: reg_rdata = CNT_W'(period);
            ADR_COUNT:  reg_rdata = cnt;
            ADR_STATUS: reg_rdata = CNT_W'(flags);
            ADR_MASK:   reg_rdata = CNT_W'(mask);
            default:    reg_rdata = '0;
        endcase
    end

    // R9: interrupt is held while an enabled flag remains and no read clears it
    a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !stat_rd && !idis_we) |=> irq_o);

    // R6: every counter increment leaves its flag set
    a_r6_inc_flag: assert property (@(posedge clk) disable iff (!rst_n)
        inc_evt |=> flags[FLG_INC]);
endmodule

// File: tb/slow_tick_timer_tb_top.sv
module slow_tick_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 16;
    localparam int TW         = 16;
    localparam int CMASK      = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic wdog_ovf_i = 1'b0;
    logic reg_we = 1'b0;
    logic reg_re = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic irq_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    slow_tick_timer #(.CNT_W(CW), .TICK_W(TW), .PRESC_RST(32768)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wdog_ovf_i(wdog_ovf_i),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    typedef struct {
        int    addr;
        int    exp;
        string tag;
    } item_t;

    item_t sb_q[$];
    int n_checks = 0;
    int n_errors = 0;

    // requirement-level model
    int m_presc = 32768, m_div = 0, m_cnt = 0, m_alarm = 0;
    int m_period = 0, m_pdiv = 0, m_flags = 0, m_mask = 0;

    task automatic model_tick();
        int lim;
        lim = (m_presc == 0) ? (1 << TW) : m_presc;
        m_div++;
        if (m_div == lim) begin
            m_div = 0;
            m_cnt = (m_cnt + 1) & CMASK;
            m_flags |= 4;
            if (m_cnt == m_alarm) m_flags |= 8;
        end
        if (m_period != 0) begin
            m_pdiv++;
            if (m_pdiv == m_period) begin
                m_pdiv = 0;
                m_flags |= 1;
            end
        end
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
        for (int i = 0; i < n; i++) model_tick();
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = CW'(d);
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            0: begin m_presc = d; m_div = 0; end
            1: m_alarm = d;
            2: begin m_period = d; m_pdiv = 0; end
            5: m_mask = m_mask | (d & 15);
            6: m_mask = m_mask & ~(d & 15);
            default: ;
        endcase
    endtask

    task automatic rd(input int a, input int e, input string tag);
        item_t it;
        @(negedge clk);
        reg_re = 1'b1; reg_addr = 3'(a);
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        reg_re = 1'b0;
        if (a == 4) m_flags = 0;
    endtask

    task automatic rd_status(input string tag);
        rd(4, m_flags, tag);
    endtask

    // status read and tick pulse in the same cycle
    task automatic tick_and_read(input string tag);
        item_t it;
        @(negedge clk);
        tick_i = 1'b1; reg_re = 1'b1; reg_addr = 3'd4;
        it.addr = 4; it.exp = m_flags; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        tick_i = 1'b0; reg_re = 1'b0;
        m_flags = 0;
        model_tick();
    endtask

    task automatic wdog_pulse();
        @(negedge clk);
        wdog_ovf_i = 1'b1;
        @(negedge clk);
        wdog_ovf_i = 1'b0;
        m_flags |= 2;
    endtask

    task automatic chk_irq(input string tag);
        int e;
        @(negedge clk);
        #(CLK_PERIOD/4);
        e = ((m_flags & m_mask) != 0) ? 1 : 0;
        n_checks++;
        if (int'(irq_o) != e) begin
            n_errors++;
            $display("FAIL %s irq actual=%0d expected=%0d", tag, irq_o, e);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (reg_re) begin
            n_checks++;
            if (sb_q.size() == 0) begin
                n_errors++;
                $display("FAIL scoreboard read with no expected item actual=%0h expected=none", reg_rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (int'(reg_rdata) != it.exp) begin
                    n_errors++;
                    $display("FAIL %s addr=%0d actual=%0h expected=%0h",
                             it.tag, it.addr, reg_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset values
        rd(0, 32768, "R3 prescaler reset");
        rd(3, 0, "R3 counter reset");
        rd(1, 0, "R3 alarm reset");
        rd(2, 0, "R3 period reset");
        rd(7, 0, "R3 mask reset");
        rd_status("R3 status reset");
        chk_irq("R3 irq reset");

        // R2 default divide of 32768
        ticks(32767);
        rd(3, m_cnt, "R2 no step before 32768 ticks");
        ticks(1);
        rd(3, m_cnt, "R2 step at 32768 ticks");
        rd_status("R6 increment flag after step");
        rd_status("R7 status cleared by read");

        // R2 reprogrammed prescaler restarts its count
        wr(0, 3);
        ticks(2);
        rd(3, m_cnt, "R2 prescaler 3 holds after 2");
        ticks(1);
        rd(3, m_cnt, "R2 prescaler 3 steps after 3");

        // R1/R4 wrap with alarm equal to current count
        wr(0, 1);
        wr(1, m_cnt);
        rd(1, m_cnt, "R4 alarm readback");
        rd_status("R6 clear before wrap");
        ticks(CMASK - m_cnt);
        rd(3, CMASK, "R1 counter at all ones");
        rd_status("R4 no alarm before wrap");
        ticks(1);
        rd(3, 0, "R1 counter wrapped to zero");
        ticks(m_alarm - 1);
        rd_status("R4 no alarm one short");
        ticks(1);
        rd_status("R4 alarm after full wrap");

        // R4 alarm ahead of the counter
        wr(1, (m_cnt + 3) & CMASK);
        ticks(2);
        rd_status("R4 alarm not yet");
        ticks(1);
        rd_status("R4 alarm fires at match");

        // R8/R9 mask and interrupt
        wr(5, 4);
        rd(7, 4, "R8 enable sets bit 2");
        chk_irq("R9 no flag no irq");
        ticks(1);
        chk_irq("R9 irq on enabled flag");
        wr(5, 0);
        rd(7, 4, "R8 enable zeros no change");
        wr(6, 0);
        rd(7, 4, "R8 disable zeros no change");
        wr(6, 4);
        rd(7, 0, "R8 disable clears bit 2");
        chk_irq("R9 masked flag no irq");
        wr(5, 10);
        rd(7, 10, "R8 enable bits 1 and 3");
        rd_status("R6 increment flag set while masked");

        // R6 watchdog flag, R9 level behaviour
        wdog_pulse();
        chk_irq("R9 irq on watchdog flag");
        chk_irq("R9 irq stays high");
        rd_status("R6 watchdog flag");
        chk_irq("R9 irq drops after read");

        // R5 interval timer
        wr(6, 15);
        wr(2, 3);
        ticks(2);
        rd_status("R5 no interval before period");
        ticks(1);
        rd_status("R5 interval at period");
        ticks(2);
        wr(2, 3);
        ticks(2);
        rd_status("R5 restart by period write");
        ticks(1);
        rd_status("R5 interval after restart");
        wr(2, 0);
        ticks(10);
        rd_status("R5 period zero no events");

        // R5 independence from the prescaler
        wr(0, 3);
        wr(2, 2);
        rd_status("R5 clear");
        ticks(2);
        rd_status("R5 interval without counter step");

        // R7 event in the same cycle as a status read
        wr(0, 1);
        wr(2, 0);
        rd_status("R7 clear before race");
        tick_and_read("R7 read returns old flags");
        rd_status("R7 event kept through read");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule